// File: doc/BRIEF.md
# I2C SCL Timing Encoder and Clock Generator

This block takes a clock divider ratio, meaning the peripheral clock frequency divided by the wanted bus speed, and turns it into a packed 32-bit timing-control word. It then uses the fields of that word to run a free-running SCL waveform generator. The encoder halves the ratio until it fits in four bits. Every halving adds one to a power-of-two prescaler exponent. Any bit discarded along the way sets a sticky round-up flag, so the reduced period is never shorter than the request.

The reduced ratio is split into a low-phase count and a high-phase count. These two counts and the exponent are packed next to constant setup, hold and bus-free fields. The generator divides the peripheral clock by 2^exponent to make base ticks. It then holds SCL low and high for the programmed numbers of base ticks, so one SCL period equals the reduced ratio in base ticks.

A fast-mode request travels with each load. It selects high-speed mode and a companion timeout word of 3; without it the timeout word is 0, meaning no timeout.

Top module: `i2c_scl_timing`

## Requirements
- R1: After reset, `timing_word` is 0x77733301 (the encoding of ratio 16), `hs_mode` is 0, `tmo_word` is 0, `scl` is 1 and `phase_tick` is 0.
- R2: While the working ratio is 16 or more, it is shifted right by one, the exponent goes up by one, and the shifted-out bit is ORed into a sticky flag. The reduced ratio is the remainder plus the sticky flag (for example 250 gives exponent 4 and reduced ratio 16).
- R3: From reduced ratio r, low = (r>>1)-1 and high = r-low-2. The word is 0x77700300 with high in bits 19:16, low in bits 15:12 and the exponent in bits 3:0. Bits 31:20 always read 0x777, bits 11:8 read 3 and bits 7:4 read 0.
- R4: An exponent above 15 is saturated to 15 in bits 3:0 (ratio 0xFFFFFFFF gives 0x7777730F).
- R5: A load with ratio 0 is ignored: `timing_word`, `hs_mode` and `tmo_word` keep their values. A ratio of 1 is encoded as a ratio of 2.
- R6: A load with `fast_req`=1 sets `hs_mode` to 1 and `tmo_word` to 3. A load with `fast_req`=0 sets them to 0 and 0. Both take effect together with the new word.
- R7: The new word appears no later than 32 cycles after the load strobe. A load arriving while an encoding is in progress replaces it, and the replaced result never appears.
- R8: While enabled, the generator restarts in the low phase one cycle after a word update. `scl` then stays low for (low+1)*2^exp clock cycles and high for (high+1)*2^exp clock cycles, repeating.
- R9: `phase_tick` is high for exactly the one cycle in which each transition of `scl` from the running generator becomes visible.
- R10: While `en` is 0, `scl` is 1 and `phase_tick` is 0. One cycle after `en` rises, `scl` is 0 and a fresh low phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | One-cycle strobe that accepts `ratio` and `fast_req` |
| ratio | input | 32 | Clock divider ratio (peripheral clock / bus speed) |
| fast_req | input | 1 | Requested speed is above 400 kHz |
| en | input | 1 | Generator enable |
| timing_word | output | 32 | Packed timing-control word |
| tmo_word | output | 32 | Companion timeout word, 3 in high-speed mode, else 0 |
| hs_mode | output | 1 | High-speed mode selected |
| scl | output | 1 | Registered SCL level |
| phase_tick | output | 1 | One-cycle strobe on each SCL transition |

## Verification
The assertions assume that reset is held for at least two cycles. They also assume that the only thing that can change the word is a load with a non-zero ratio, so the word must stay constant once 40 cycles have passed without such a load. They further assume that `en` and `load` are synchronous levels sampled on the rising edge. The bench drives every input on the falling edge. It waits at least 32 cycles after each load, except in the one test that deliberately overlaps two loads. It measures phase lengths only for words with small exponents, so each waveform completes well within the run.

// File: rtl/i2c_tmg_pkg.sv
// Package: shared constants and the elaboration-time encoder used for the
// reset value of the timing word. Assumes a 32-bit timing word layout.
package i2c_tmg_pkg;

    localparam int WORD_W    = 32;
    localparam int FLD_W     = 4;
    localparam int HI_LSB    = 16;
    localparam int LO_LSB    = 12;
    localparam int EXP_LSB   = 0;
    localparam logic [WORD_W-1:0] FIXED_WORD = 32'h7770_0300;
    localparam logic [WORD_W-1:0] TMO_FAST   = 32'd3;
    localparam logic [WORD_W-1:0] TMO_SLOW   = 32'd0;

    // Elaboration-time encoding of a ratio (used for the reset word only).
    function automatic logic [WORD_W-1:0] encode_ratio(input logic [31:0] r_in);
        logic [31:0] w;
        int          e;
        logic        st;
        int          red;
        int          lo;
        int          hi;
        w  = (r_in < 2) ? 32'd2 : r_in;
        e  = 0;
        st = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (w >= 32'd16) begin
                st = st | w[0];
                w  = w >> 1;
                e  = e + 1;
            end
        end
        red = int'(w) + int'(st);
        lo  = (red >> 1) - 1;
        hi  = red - lo - 2;
        if (e > 15) e = 15;
        return FIXED_WORD | (WORD_W'(hi) << HI_LSB) | (WORD_W'(lo) << LO_LSB) | WORD_W'(e);
    endfunction

endpackage

// File: rtl/i2c_ratio_norm.sv
// Ratio normaliser: iteratively halves the accepted ratio until it fits in
// FLD_W bits, counting halvings and keeping a sticky OR of dropped bits.
// Assumes start is only raised with a ratio of at least 2; a new start
// during a run restarts it. Emits a one-cycle done with the result.
module i2c_ratio_norm #(
    parameter int RATIO_W = 32,
    parameter int FLD_W   = 4,
    parameter int CNT_W   = $clog2(RATIO_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               done,
    output logic [FLD_W:0]     red,
    output logic [CNT_W-1:0]   exp_out
);
    localparam logic [RATIO_W-1:0] THRESH = RATIO_W'(1) << FLD_W;

    logic [RATIO_W-1:0] work;
    logic [CNT_W-1:0]   exp_c;
    logic               sticky;
    logic               busy;

    // Shift-and-count sequencer with sticky round-up, result on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work    <= '0;
            exp_c   <= '0;
            sticky  <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            red     <= '0;
            exp_out <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                work   <= ratio_in;
                exp_c  <= '0;
                sticky <= 1'b0;
                busy   <= 1'b1;
            end else if (busy) begin
                if (work >= THRESH) begin
                    work   <= work >> 1;
                    exp_c  <= exp_c + 1'b1;
                    sticky <= sticky | work[0];
                end else begin
                    red     <= {1'b0, work[FLD_W-1:0]} + {{FLD_W{1'b0}}, sticky};
                    exp_out <= exp_c;
                    done    <= 1'b1;
                    busy    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_phase_split.sv
// Phase splitter and packer: derives low/high phase counts from the reduced
// ratio, saturates the exponent to the field width, and builds the word.
// Assumes red is between 2 and 2**FLD_W inclusive. Purely combinational.
module i2c_phase_split
    import i2c_tmg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [FLD_W:0]      red,
    input  logic [CNT_W-1:0]    exp_in,
    output logic [WORD_W-1:0]   word
);
    localparam logic [CNT_W-1:0] EXP_MAX = CNT_W'((1 << FLD_W) - 1);

    logic [FLD_W:0]   low_w;
    logic [FLD_W:0]   high_w;
    logic [FLD_W-1:0] exp_sat;

    // Split period into phases and pack them beside the fixed fields.
    always_comb begin
        low_w   = (red >> 1) - {{FLD_W{1'b0}}, 1'b1};
        high_w  = red - low_w - (FLD_W+1)'(2);
        exp_sat = (exp_in > EXP_MAX) ? EXP_MAX[FLD_W-1:0] : exp_in[FLD_W-1:0];
        word    = FIXED_WORD
                | (WORD_W'(high_w[FLD_W-1:0]) << HI_LSB)
                | (WORD_W'(low_w[FLD_W-1:0])  << LO_LSB)
                | (WORD_W'(exp_sat)           << EXP_LSB);
    end
endmodule

// File: rtl/i2c_scl_gen.sv
// SCL phase generator: a 2**exp prescaler makes base ticks; SCL is held low
// for low+1 ticks and high for high+1 ticks. Restarts in the low phase on
// restart or when enable rises; idles high while disabled. Field inputs
// are assumed stable except at restart.
module i2c_scl_gen #(
    parameter int FLD_W = 4,
    parameter int PRE_W = (1 << FLD_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [FLD_W-1:0] low_cnt,
    input  logic [FLD_W-1:0] high_cnt,
    input  logic [FLD_W-1:0] exp_in,
    output logic             scl,
    output logic             tick
);
    logic [PRE_W:0]   one_sh;
    logic [PRE_W:0]   lim_w;
    logic [PRE_W-1:0] pre_lim;
    logic [PRE_W-1:0] pre_cnt;
    logic [FLD_W-1:0] ph_cnt;
    logic [FLD_W-1:0] ph_lim;
    logic             armed;

    // Prescaler limit and the phase length for the current level.
    always_comb begin
        one_sh  = (PRE_W+1)'(1) << exp_in;
        lim_w   = one_sh - (PRE_W+1)'(1);
        pre_lim = lim_w[PRE_W-1:0];
        ph_lim  = scl ? high_cnt : low_cnt;
    end

    // Prescaler, phase counter and SCL toggle with its tick strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            scl     <= 1'b1;
            tick    <= 1'b0;
            armed   <= 1'b0;
            pre_cnt <= '0;
            ph_cnt  <= '0;
        end else if (restart || !armed) begin
            scl     <= 1'b0;
            tick    <= 1'b0;
            armed   <= 1'b1;
            pre_cnt <= '0;
            ph_cnt  <= '0;
        end else begin
            tick <= 1'b0;
            if (pre_cnt == pre_lim) begin
                pre_cnt <= '0;
                if (ph_cnt == ph_lim) begin
                    ph_cnt <= '0;
                    scl    <= ~scl;
                    tick   <= 1'b1;
                end else begin
                    ph_cnt <= ph_cnt + 1'b1;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_scl_timing.sv
// Top: accepts a divider ratio on load, encodes it into the timing word over
// a few cycles, registers the word with the speed-mode outputs, and drives
// the SCL generator from the word's fields. Zero ratios are dropped;
// a ratio of 1 is raised to 2.
module i2c_scl_timing
    import i2c_tmg_pkg::*;
#(
    parameter int          RATIO_W     = 32,
    parameter logic [31:0] RESET_RATIO = 32'd16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               fast_req,
    input  logic               en,
    output logic [WORD_W-1:0]  timing_word,
    output logic [WORD_W-1:0]  tmo_word,
    output logic               hs_mode,
    output logic               scl,
    output logic               phase_tick
);
    localparam int CNT_W = $clog2(RATIO_W) + 1;
    localparam logic [WORD_W-1:0] RESET_WORD = encode_ratio(RESET_RATIO);

    logic               accept;
    logic [RATIO_W-1:0] ratio_adj;
    logic               fast_pend;
    logic               nrm_done;
    logic [FLD_W:0]     nrm_red;
    logic [CNT_W-1:0]   nrm_exp;
    logic [WORD_W-1:0]  new_word;
    logic               upd_q;

    // Load qualification and the minimum-ratio adjustment.
    always_comb begin
        accept    = load && (ratio != '0);
        ratio_adj = (ratio == RATIO_W'(1)) ? RATIO_W'(2) : ratio;
    end

    i2c_ratio_norm #(.RATIO_W(RATIO_W), .FLD_W(FLD_W), .CNT_W(CNT_W)) u_norm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .ratio_in (ratio_adj),
        .done     (nrm_done),
        .red      (nrm_red),
        .exp_out  (nrm_exp)
    );

    i2c_phase_split #(.CNT_W(CNT_W)) u_split (
        .red    (nrm_red),
        .exp_in (nrm_exp),
        .word   (new_word)
    );

    // Capture the speed request and commit word and mode on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_pend   <= 1'b0;
            timing_word <= RESET_WORD;
            tmo_word    <= TMO_SLOW;
            hs_mode     <= 1'b0;
            upd_q       <= 1'b0;
        end else begin
            if (accept) fast_pend <= fast_req;
            upd_q <= nrm_done;
            if (nrm_done) begin
                timing_word <= new_word;
                hs_mode     <= fast_pend;
                tmo_word    <= fast_pend ? TMO_FAST : TMO_SLOW;
            end
        end
    end

    i2c_scl_gen #(.FLD_W(FLD_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .restart  (upd_q),
        .low_cnt  (timing_word[LO_LSB +: FLD_W]),
        .high_cnt (timing_word[HI_LSB +: FLD_W]),
        .exp_in   (timing_word[EXP_LSB +: FLD_W]),
        .scl      (scl),
        .tick     (phase_tick)
    );
endmodule

// File: rtl/i2c_scl_timing_chk.sv
// Checker: temporal properties of the timing block, bound to the top.
// Assumes reset is held for at least two cycles.
module i2c_scl_timing_chk #(
    parameter int RATIO_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic [RATIO_W-1:0] ratio,
    input logic               en,
    input logic [31:0]        timing_word,
    input logic               scl,
    input logic               phase_tick
);
    logic [5:0] since_load;

    // Cycles since the last accepted load, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_load <= 6'd63;
        else if (load && (ratio != '0))      since_load <= 6'd0;
        else if (since_load != 6'd63)        since_load <= since_load + 6'd1;
    end

    a_r3_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_word & 32'hFFF0_0FF0) == 32'h7770_0300);

    a_r3_phase_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_word[19:16] == timing_word[15:12]) ||
        (timing_word[19:16] == timing_word[15:12] + 4'd1));

    a_r9_tick_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> (scl != $past(scl)));

    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl && !phase_tick));

    a_r7_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (since_load >= 6'd40) |-> $stable(timing_word));
endmodule

bind i2c_scl_timing i2c_scl_timing_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .ratio       (ratio),
    .en          (en),
    .timing_word (timing_word),
    .scl         (scl),
    .phase_tick  (phase_tick)
);

// File: tb/sim_i2c_scl_timing.sv
module sim_i2c_scl_timing;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] ratio = '0;
    logic        fast_req = 1'b0;
    logic        en = 1'b0;
    logic [31:0] timing_word;
    logic [31:0] tmo_word;
    logic        hs_mode;
    logic        scl;
    logic        phase_tick;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_scl_timing u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .ratio(ratio),
        .fast_req(fast_req), .en(en), .timing_word(timing_word),
        .tmo_word(tmo_word), .hs_mode(hs_mode), .scl(scl),
        .phase_tick(phase_tick)
    );

    // {fast_req, ratio, expected word}
    localparam int NV = 13;
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'd15,         32'h7777_6300},
        {1'b0, 32'd16,         32'h7773_3301},
        {1'b1, 32'd17,         32'h7774_3301},
        {1'b0, 32'd31,         32'h7777_7301},
        {1'b1, 32'd250,        32'h7777_7304},
        {1'b0, 32'd1000,       32'h7777_7306},
        {1'b0, 32'd2,          32'h7770_0300},
        {1'b0, 32'd1,          32'h7770_0300},
        {1'b0, 32'd3,          32'h7771_0300},
        {1'b1, 32'd40,         32'h7774_4302},
        {1'b0, 32'hFFFF_FFFF,  32'h7777_730F},
        {1'b0, 32'h8000_0000,  32'h7773_330F},
        {1'b0, 32'h0001_0000,  32'h7773_330D}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic f, input logic [31:0] r);
        @(negedge clk);
        load = 1'b1; ratio = r; fast_req = f;
        @(negedge clk);
        load = 1'b0; ratio = '0; fast_req = 1'b0;
    endtask

    // After a load with en=1: find the word update, then measure one low and
    // one high phase in clock cycles and check the tick strobe alongside.
    task automatic measure(input logic [31:0] r, input int exp_lo, input int exp_hi);
        logic [31:0] old_w;
        int lo = 0;
        int hi = 0;
        int bad_tick = 0;
        int guard = 0;
        logic prev;
        old_w = timing_word;
        do_load(1'b0, r);
        while (timing_word == old_w && guard < 64) begin
            @(negedge clk); guard++;
        end
        @(negedge clk);
        chk("R8 restart low", {31'd0, scl}, 32'd0);
        prev = scl;
        while (scl == 1'b0 && lo < 200) begin
            lo++;
            @(negedge clk);
            if (phase_tick !== (scl != prev)) bad_tick++;
            prev = scl;
        end
        while (scl == 1'b1 && hi < 200) begin
            hi++;
            @(negedge clk);
            if (phase_tick !== (scl != prev)) bad_tick++;
            prev = scl;
        end
        chk("R8 low length", lo, exp_lo);
        chk("R8 high length", hi, exp_hi);
        chk("R9 tick with toggle", bad_tick, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 word", timing_word, 32'h7773_3301);
        chk("R1 hs_mode", {31'd0, hs_mode}, 32'd0);
        chk("R1 tmo_word", tmo_word, 32'd0);
        chk("R1 scl", {31'd0, scl}, 32'd1);
        chk("R1 tick", {31'd0, phase_tick}, 32'd0);

        // R2 R3 R4 R5 R6 R7: vector table, word read 32 cycles after load
        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i][64], VEC[i][63:32]);
            repeat (31) @(negedge clk);
            chk("R2/R3/R4/R7 word", timing_word, VEC[i][31:0]);
            chk("R6 hs_mode", {31'd0, hs_mode}, {31'd0, VEC[i][64]});
            chk("R6 tmo_word", tmo_word, VEC[i][64] ? 32'd3 : 32'd0);
        end

        // R8 R9: generator phase lengths
        en = 1'b1;
        measure(32'd40, 20, 20);
        measure(32'd17, 8, 10);
        measure(32'd3, 1, 2);

        // R10: disable idles high, enable restarts low
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R10 idle scl", {31'd0, scl}, 32'd1);
        chk("R10 idle tick", {31'd0, phase_tick}, 32'd0);
        repeat (5) @(negedge clk);
        chk("R10 idle scl held", {31'd0, scl}, 32'd1);
        en = 1'b1;
        @(negedge clk);
        chk("R10 restart low", {31'd0, scl}, 32'd0);
        @(negedge clk);
        chk("R10 low then high", {31'd0, scl}, 32'd1);

        // R5: zero ratio ignored, previous config kept
        do_load(1'b1, 32'd250);
        repeat (40) @(negedge clk);
        do_load(1'b0, 32'd0);
        repeat (40) @(negedge clk);
        chk("R5 zero keeps word", timing_word, 32'h7777_7304);
        chk("R5 zero keeps hs", {31'd0, hs_mode}, 32'd1);
        chk("R5 zero keeps tmo", tmo_word, 32'd3);

        // R7: a second load during encoding supersedes the first
        begin
            int seen = 0;
            @(negedge clk);
            load = 1'b1; ratio = 32'd1000; fast_req = 1'b1;
            @(negedge clk);
            ratio = 32'd15; fast_req = 1'b0;
            @(negedge clk);
            load = 1'b0; ratio = '0;
            for (int k = 0; k < 40; k++) begin
                if (timing_word == 32'h7777_7306) seen++;
                @(negedge clk);
            end
            chk("R7 superseded never shown", seen, 0);
            chk("R7 latest word", timing_word, 32'h7777_6300);
            chk("R6 latest mode", {31'd0, hs_mode}, 32'd0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule